// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Refresh

This block guards a small 8-bit controller against a hung program. A prescaler divides the oscillator clock by a fixed ratio. An optional second stage adds a further divide-by-16. The prescaler output advances a 15-bit up-counter. When the counter passes its all-ones value, the block raises a system reset request for a fixed number of cycles. It also sets a sticky status flag that software can read after the reset.

Software programs an 8-bit reload value. The low 7 bits form the counter's upper bits at each reload, and the top bit selects the long prescale. Software starts the watchdog and refreshes it with the same two-step sequence: a write to the first trigger, then a write to the second trigger as the very next bus write. After power-on the watchdog is stopped and all of its registers are zero. It stays idle until the first accepted sequence.

Top module: `wdog_core`

## Requirements
- R1: Power-on reset (`rst`, synchronous, active high) clears `rst_req`, `wd_flag` and all state. Afterwards the watchdog stays stopped, and `rst_req` stays low, until a start sequence is accepted.
- R2: With reload bit 7 = 0, `rst_req` rises exactly 24 × (32768 − reload[6:0] × 256) clock edges after the edge that accepts a refresh.
- R3: With reload bit 7 = 1, that interval is 384 × (32768 − reload[6:0] × 256) edges.
- R4: A refresh is accepted when a write with `wr_sel` = 2'b10 (second trigger) directly follows a write with `wr_sel` = 2'b01 (first trigger). Idle cycles without `wr_en` may separate the two writes. An accepted refresh restarts the timeout interval and leaves the watchdog running.
- R5: Any other write between the first and the second trigger cancels the pending refresh. This includes a write with `wr_sel` = 2'b00 (reload register) or 2'b11 (no register).
- R6: A second-trigger write that is not directly preceded by a first-trigger write is ignored and does not move the timeout.
- R7: A write to the reload register (`wr_sel` = 2'b00, value on `wr_data`) changes the interval only from the next accepted refresh onward.
- R8: On a timeout, `rst_req` is high for exactly 4 clock cycles and then drops.
- R9: `wd_flag` goes high on the same edge as `rst_req` and stays high until power-on reset.
- R10: After a timeout the watchdog is stopped and raises no further request until the next accepted start sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 2 | Write target: 00 reload, 01 first trigger, 10 second trigger, 11 none |
| wr_data | input | 8 | Write data; used for the reload register only |
| rst_req | output | 1 | System reset request, registered |
| wd_flag | output | 1 | Sticky flag showing that a watchdog timeout occurred |

## Verification
The accepting edge of a refresh reloads the counter and clears the prescaler. `rst_req` therefore rises on exactly the edge that is the period count later, and `wd_flag` rises on that same edge. `rst_req` then stays high for four sampled cycles. The bench keeps a free-running edge count and records its value just after each accepting edge. It samples `rst_req` at the falling edge, and it requires the gap to the first high sample to equal the computed period to the cycle. The hold length is checked sample by sample on the four falling edges that follow. Randomized trigger sequences are scored by a bench model of the arming rule, which gives the edge of the last accepted refresh.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'b00,
    SEL_TRIG_R = 2'b01,
    SEL_TRIG_S = 2'b10,
    SEL_SPARE  = 2'b11
  } wsel_e;
endpackage

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  wsel_e wr_sel,
  output logic  accept
);
  logic armed;

  // Armed only by a first-trigger write; any other write disarms.
  always_ff @(posedge clk) begin
    if (rst)        armed <= 1'b0;
    else if (wr_en) armed <= (wr_sel == SEL_TRIG_R);
  end

  assign accept = wr_en && (wr_sel == SEL_TRIG_S) && armed;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_DIV = 24,
  parameter int EXT_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic long_sel,
  output logic tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);
  localparam logic [EW-1:0] EXT_LAST = EW'(EXT_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [EW-1:0] ext_q;
  logic          pre_wrap;

  assign pre_wrap = en && (pre_q == PRE_LAST);
  assign tick     = pre_wrap && (!long_sel || (ext_q == EXT_LAST));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      ext_q <= '0;
    end else if (en) begin
      pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (pre_wrap)
        ext_q <= (ext_q == EXT_LAST) ? '0 : ext_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int REL_W = 7,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REL_W-1:0] load_val,
  input  logic             tick,
  output logic             run,
  output logic             expire
);
  localparam int CW = REL_W + LOW_W;

  logic [CW-1:0] cnt_q;

  // Timeout is the tick that would carry out of the all-ones count.
  assign expire = run && tick && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run   <= 1'b0;
    end else if (load) begin
      cnt_q <= {load_val, {LOW_W{1'b0}}};
      run   <= 1'b1;
    end else if (expire) begin
      cnt_q <= '0;
      run   <= 1'b0;
    end else if (run && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int PRE_DIV  = 24,
  parameter int EXT_DIV  = 16,
  parameter int REL_W    = 7,
  parameter int LOW_W    = 8,
  parameter int HOLD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REL_W:0]   wr_data,
  output logic             rst_req,
  output logic             wd_flag
);
  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  wsel_e          sel;
  logic           accept;
  logic           tick;
  logic           run;
  logic           expire;
  logic [REL_W:0] rel_q;
  logic           long_q;
  logic [HW-1:0]  hold_q;

  assign sel = wsel_e'(wr_sel);

  wdog_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_sel (sel),
    .accept (accept)
  );

  wdog_prescale #(.PRE_DIV(PRE_DIV), .EXT_DIV(EXT_DIV)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .en       (run),
    .long_sel (long_q),
    .tick     (tick)
  );

  wdog_count #(.REL_W(REL_W), .LOW_W(LOW_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (rel_q[REL_W-1:0]),
    .tick     (tick),
    .run      (run),
    .expire   (expire)
  );

  // Reload register; its prescale bit is captured only on a refresh.
  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q  <= '0;
      long_q <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_RELOAD) rel_q <= wr_data;
      if (accept)                     long_q <= rel_q[REL_W];
    end
  end

  // Reset request pulse of fixed length and sticky cause flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      hold_q  <= '0;
      wd_flag <= 1'b0;
    end else if (expire) begin
      rst_req <= 1'b1;
      hold_q  <= '0;
      wd_flag <= 1'b1;
    end else if (rst_req) begin
      if (hold_q == HOLD_LAST) rst_req <= 1'b0;
      hold_q <= hold_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk (
  input logic clk,
  input logic rst,
  input logic rst_req,
  input logic wd_flag,
  input logic expire,
  input logic run
);
  logic [3:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                          hi_cnt <= '0;
    else if (rst_req && hi_cnt != 4'hF) hi_cnt <= hi_cnt + 1'b1;
    else if (!rst_req)                hi_cnt <= '0;
  end

  assert_por_clear_R1: assert property (@(posedge clk)
    rst |=> (!rst_req && !wd_flag));

  assert_hold_len_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req) |-> (hi_cnt == 4'd4));

  assert_hold_cap_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (hi_cnt < 4'd4));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    wd_flag |=> wd_flag);

  assert_flag_with_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> wd_flag);

  assert_stop_after_timeout_R10: assert property (@(posedge clk) disable iff (rst)
    expire |=> (!run && rst_req));
endmodule

bind wdog_core wdog_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .rst_req (rst_req),
  .wd_flag (wd_flag),
  .expire  (expire),
  .run     (run)
);

// File: tb/wdog_core_bench.sv
module wdog_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'b11;
  logic [7:0] wr_data = 8'h00;
  logic       rst_req;
  logic       wd_flag;

  int      n_chk = 0;
  int      n_fail = 0;
  longint  cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_core u_wdog_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rst_req(rst_req), .wd_flag(wd_flag)
  );

  function automatic longint period(input logic [7:0] rel);
    longint ticks = 32768 - longint'(rel[6:0]) * 256;
    return (rel[7] ? 384 : 24) * ticks;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One bus write, sampled at the next rising edge.
  task automatic bus(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0; wr_sel = 2'b11;
  endtask

  task automatic refresh(output longint at);
    bus(2'b01, 8'h00);
    bus(2'b10, 8'h00);
    at = cyc;
  endtask

  task automatic wait_rise(input longint maxc, output longint at);
    at = -1;
    for (longint i = 0; i < maxc && at < 0; i++) begin
      @(negedge clk);
      if (rst_req) at = cyc;
    end
  endtask

  task automatic check_hold(input string req);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rst_req == 1'b1, req, rst_req, 1);
    end
    @(negedge clk);
    chk(rst_req == 1'b0, req, rst_req, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (198000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    longint t0, t1, p, ms_x10;
    bit armed;
    logic [1:0] s;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(rst_req == 0, "R1 reset rst_req", rst_req, 0);
    chk(wd_flag == 0, "R1 reset flag", wd_flag, 0);
    idle(200);
    chk(rst_req == 0 && wd_flag == 0, "R1 stopped before start", rst_req, 0);

    // Period formula against the expected timeouts at 14.74 MHz (0.1 ms units)
    ms_x10 = (period(8'h00) * 10000 + 7370000) / 14740000;
    chk(ms_x10 == 534 || ms_x10 == 533, "R2 00h near 53.3ms", ms_x10, 533);
    ms_x10 = (period(8'h4F) * 10000 + 7370000) / 14740000;
    chk(ms_x10 == 204, "R2 4Fh near 20.4ms", ms_x10, 204);
    ms_x10 = (period(8'hCC) * 10000 + 7370000) / 14740000;
    chk(ms_x10 == 3468 || ms_x10 == 3470, "R3 CCh near 347ms", ms_x10, 3470);

    // R2/R4 basic start and timeout, R8 hold, R9 flag, R10 stop
    bus(2'b00, 8'h7F);
    refresh(t0);
    wait_rise(period(8'h7F) + 10, t1);
    chk(t1 - t0 == period(8'h7F), "R2 period reload 7Fh", t1 - t0, period(8'h7F));
    chk(wd_flag == 1, "R9 flag with request", wd_flag, 1);
    check_hold("R8 hold four cycles");
    idle(7000);
    chk(rst_req == 0, "R10 stopped after timeout", rst_req, 0);
    chk(wd_flag == 1, "R9 flag sticky", wd_flag, 1);

    // R4 refresh mid-run restarts the interval
    refresh(t0);
    idle(3000);
    refresh(t0);
    wait_rise(period(8'h7F) + 10, t1);
    chk(t1 - t0 == period(8'h7F), "R4 refresh restarts", t1 - t0, period(8'h7F));
    check_hold("R8 hold after refresh");

    // R5 intervening write cancels
    refresh(t0);
    idle(3000);
    bus(2'b01, 8'h00);
    bus(2'b11, 8'h00);
    bus(2'b10, 8'h00);
    wait_rise(period(8'h7F) + 10, t1);
    chk(t1 - t0 == period(8'h7F), "R5 cancelled refresh", t1 - t0, period(8'h7F));
    check_hold("R8 hold R5");

    // R6 lone second trigger ignored
    refresh(t0);
    idle(3000);
    bus(2'b10, 8'h00);
    wait_rise(period(8'h7F) + 10, t1);
    chk(t1 - t0 == period(8'h7F), "R6 lone S ignored", t1 - t0, period(8'h7F));
    check_hold("R8 hold R6");

    // R7 reload write while running waits for the next refresh
    refresh(t0);
    idle(1000);
    bus(2'b00, 8'h7E);
    wait_rise(period(8'h7F) + 10, t1);
    chk(t1 - t0 == period(8'h7F), "R7 reload deferred", t1 - t0, period(8'h7F));
    check_hold("R8 hold R7");
    refresh(t0);
    wait_rise(period(8'h7E) + 10, t1);
    chk(t1 - t0 == period(8'h7E), "R7 reload applied", t1 - t0, period(8'h7E));
    check_hold("R8 hold R7 new");

    // Random trigger streams scored by an arming model (R4 R5 R6)
    bus(2'b00, 8'h7F);
    for (int r = 0; r < 2; r++) begin
      refresh(t0);
      idle(500);
      armed = 0;
      for (int k = 0; k < 24; k++) begin
        s = 2'($urandom_range(1, 3));
        if (s == 2'b00) s = 2'b11;
        bus(s, 8'h7F);
        if (s == 2'b10 && armed) t0 = cyc;
        armed = (s == 2'b01);
      end
      wait_rise(period(8'h7F) + 10, t1);
      chk(t1 - t0 == period(8'h7F), "R4 random trigger stream", t1 - t0, period(8'h7F));
      check_hold("R8 hold random");
    end

    // R3 long prescale
    bus(2'b00, 8'hFF);
    refresh(t0);
    wait_rise(period(8'hFF) + 10, t1);
    chk(t1 - t0 == period(8'hFF), "R3 period reload FFh", t1 - t0, period(8'hFF));
    check_hold("R8 hold R3");

    // R1 power-on clears the flag
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(wd_flag == 0, "R1 power-on clears flag", wd_flag, 0);
    finish_run();
  end
endmodule